// File: doc/BRIEF.md
# Latched Fault Status Reporter

This block drives one active-high diagnostic line for an eight-channel output driver. The line goes high while any channel reports a short, while the die is overheated, or while every command bit is zero. Zero command bits mean standby, and the high line then acts as a self-test of the status path. The block also holds three latched conditions: a frame that was too short, a frame that was too long, and an overheat event. Each latched condition is released on a different falling serial-clock edge of a later frame. A host that watches when the line drops can therefore tell which fault occurred.

The serial receiver supplies single-cycle pulses that are already synchronized to the system clock. These mark chip-select falling, chip-select rising, serial-clock rising and serial-clock falling. A frame tracker state machine follows each frame.
- Its states are `FR_IDLE` (select high), `FR_SHIFT` (select low, at most the frame length of falling clocks counted) and `FR_OVERRUN` (select low, a clock beyond the frame length seen).
- Transition *open* goes `FR_IDLE`→`FR_SHIFT` on select falling and clears the falling-edge ordinal counter.
- Transition *close* goes `FR_SHIFT`→`FR_IDLE` on select rising.
- Transition *overflow* goes `FR_SHIFT`→`FR_OVERRUN` on a rising clock after the full count of falling clocks.
- Transition *abort* goes `FR_OVERRUN`→`FR_IDLE` on select rising.

Falling clocks are numbered from 1 after select falls. The status output is a register, so it reflects an event one system clock after the cycle in which the event pulse is present.

Top module: `fault_status_reporter`

## Requirements
- R1: If any bit of `short_flags` is 1 in a cycle, `status` is 1 in the following cycle.
- R2: If `overtemp` is 1 for one or more cycles, `status` becomes 1 in the next cycle. It stays 1 after `overtemp` returns to 0, until a release as in R9.
- R3: If `cmd_bits` equals all zeros (standby), `status` is 1 in the following cycle.
- R4: With no short, no overheat, a nonzero `cmd_bits` and no latched condition, `status` is 0. A frame of exactly 8 falling clocks sets no latch.
- R5: A select rising edge that ends a frame with fewer than 8 falling clocks latches a short-frame error. `status` is 1 from the next cycle on.
- R6: A latched short-frame error stays set through falling clocks 1 to 7 of a later frame. It is released by falling clock 8 of that frame.
- R7: A rising clock while select is low, after 8 falling clocks, latches a long-frame error. `status` is 1 in the next cycle and stays 1 through the rest of that frame.
- R8: A latched long-frame error stays set through falling clock 1 of the next frame. It is released by falling clock 2 of that frame.
- R9: The latched overheat is released by falling clock 4 of a frame only if `overtemp` is 0 in that cycle. If `overtemp` is 1 then, the latch remains set.
- R10: `status` is 0 while `rst_n` is low, and reset clears all three latches.
- R11: When a set and a release of the same latch fall in the same cycle, the latch stays set. An example is select rising together with falling clock 8 after only 7 counted clocks.
- R12: Serial clock pulses while select is high release no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_fall | input | 1 | One-cycle pulse: chip-select went low |
| cs_rise | input | 1 | One-cycle pulse: chip-select went high |
| sclk_rise | input | 1 | One-cycle pulse: serial clock rising edge |
| sclk_fall | input | 1 | One-cycle pulse: serial clock falling edge |
| short_flags | input | NCH | Per-channel short-circuit flags, 1 = short |
| overtemp | input | 1 | Debounced overheat flag, 1 = hot |
| cmd_bits | input | NCH | Command register contents, 1 = channel on |
| status | output | 1 | Registered diagnostic line, 1 = fault or standby |

## Verification
The checker tests some rules on every cycle:
- a live short, overheat or standby raises the line one cycle later;
- the two frame-error latches never drop except in a cycle with a falling serial clock;
- the overheat latch releases only on a falling clock with the overheat input low.

Only the bench scenarios can show that each release happens on exactly the right ordinal: the 8th, 2nd or 4th falling clock, and not the one before. The same holds for the set-wins case, for falling clocks ignored while select is high, and for frames of exactly eight clocks leaving no error.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_OVERRUN
    } frame_state_t;

    // Latch indices inside the flag vector
    localparam int F_FRAME_SHORT = 0;
    localparam int F_FRAME_LONG  = 1;
    localparam int F_HEAT        = 2;
    localparam int NFLAG         = 3;

endpackage

// File: rtl/fsr_flag.sv
module fsr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q_next
);

    logic q;

    // Set has priority over release
    always_comb begin
        q_next = set | (q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/fsr_frame_tracker.sv
module fsr_frame_tracker
    import fsr_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int CLR_SHORT  = 8,
    parameter int CLR_OVER   = 2,
    parameter int CLR_OT     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic short_set,
    output logic short_clr,
    output logic over_set,
    output logic over_clr,
    output logic ot_clr_win
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] ORD_SHORT = CNT_W'(CLR_SHORT - 1);
    localparam logic [CNT_W-1:0] ORD_OVER  = CNT_W'(CLR_OVER - 1);
    localparam logic [CNT_W-1:0] ORD_OT    = CNT_W'(CLR_OT - 1);

    frame_state_t     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Transitions: open, close, overflow, abort
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            FR_IDLE: begin
                if (cs_fall) begin
                    state_n = FR_SHIFT;
                    cnt_n   = '0;
                end
            end
            FR_SHIFT: begin
                if (cs_rise) begin
                    state_n = FR_IDLE;
                end else if (sclk_rise && (cnt == FULL)) begin
                    state_n = FR_OVERRUN;
                end else if (sclk_fall && (cnt != FULL)) begin
                    cnt_n = cnt + 1'b1;
                end
            end
            FR_OVERRUN: begin
                if (cs_rise) begin
                    state_n = FR_IDLE;
                end
            end
            default: begin
                state_n = FR_IDLE;
            end
        endcase
    end

    // Event strobes toward the latches
    always_comb begin
        short_set  = 1'b0;
        short_clr  = 1'b0;
        over_set   = 1'b0;
        over_clr   = 1'b0;
        ot_clr_win = 1'b0;
        unique case (state)
            FR_IDLE: begin
            end
            FR_SHIFT: begin
                short_set  = cs_rise && (cnt < FULL);
                over_set   = sclk_rise && (cnt == FULL) && !cs_rise;
                short_clr  = sclk_fall && (cnt == ORD_SHORT);
                over_clr   = sclk_fall && (cnt == ORD_OVER);
                ot_clr_win = sclk_fall && (cnt == ORD_OT);
            end
            FR_OVERRUN: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fault_status_reporter.sv
module fault_status_reporter
    import fsr_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int FRAME_BITS = 8,
    parameter int CLR_SHORT  = 8,
    parameter int CLR_OVER   = 2,
    parameter int CLR_OT     = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_fall,
    input  logic           cs_rise,
    input  logic           sclk_rise,
    input  logic           sclk_fall,
    input  logic [NCH-1:0] short_flags,
    input  logic           overtemp,
    input  logic [NCH-1:0] cmd_bits,
    output logic           status
);

    logic             short_set, short_clr, over_set, over_clr, ot_clr_win;
    logic [NFLAG-1:0] set_vec, clr_vec, flag_next;
    logic             status_q;

    fsr_frame_tracker #(
        .FRAME_BITS (FRAME_BITS),
        .CLR_SHORT  (CLR_SHORT),
        .CLR_OVER   (CLR_OVER),
        .CLR_OT     (CLR_OT)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .short_set  (short_set),
        .short_clr  (short_clr),
        .over_set   (over_set),
        .over_clr   (over_clr),
        .ot_clr_win (ot_clr_win)
    );

    always_comb begin
        set_vec[F_FRAME_SHORT] = short_set;
        set_vec[F_FRAME_LONG]  = over_set;
        set_vec[F_HEAT]        = overtemp;
        clr_vec[F_FRAME_SHORT] = short_clr;
        clr_vec[F_FRAME_LONG]  = over_clr;
        clr_vec[F_HEAT]        = ot_clr_win & ~overtemp;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        fsr_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (set_vec[g]),
            .clr    (clr_vec[g]),
            .q_next (flag_next[g])
        );
    end

    // Output register: OR of live faults, latches and standby self-test
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= (|short_flags) | overtemp | (|flag_next) | (cmd_bits == '0);
        end
    end

    assign status = status_q;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_fall,
    input logic             overtemp,
    input logic [NCH-1:0]   short_flags,
    input logic [NCH-1:0]   cmd_bits,
    input logic [NFLAG-1:0] flag_next,
    input logic             status
);

    a_r1_short_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|short_flags) |=> status);

    a_r2_heat_raises: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |=> status);

    a_r3_standby_selftest: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bits == '0) |=> status);

    a_r6_short_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_next[F_FRAME_SHORT] |=> (flag_next[F_FRAME_SHORT] || sclk_fall));

    a_r8_long_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_next[F_FRAME_LONG] |=> (flag_next[F_FRAME_LONG] || sclk_fall));

    a_r9_heat_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_next[F_HEAT]) |-> (sclk_fall && !overtemp));

endmodule

bind fault_status_reporter fsr_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_fall   (sclk_fall),
    .overtemp    (overtemp),
    .short_flags (short_flags),
    .cmd_bits    (cmd_bits),
    .flag_next   (flag_next),
    .status      (status)
);

// File: tb/fault_status_reporter_test.sv
module fault_status_reporter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_fall = 1'b0, cs_rise = 1'b0, sclk_rise = 1'b0, sclk_fall = 1'b0;
    logic [7:0] short_flags = '0;
    logic       overtemp = 1'b0;
    logic [7:0] cmd_bits = 8'h5A;
    logic       status;

    int n_chk = 0;
    int n_err = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    fault_status_reporter uut (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .short_flags(short_flags),
        .overtemp(overtemp), .cmd_bits(cmd_bits), .status(status)
    );

    // Reference model written from the requirements
    int ms = 0;
    int mc = 0;
    bit mse = 0, moe = 0, mot = 0, exp_status = 0;

    function automatic bit expect_line(bit se, bit oe, bit ot);
        return (|short_flags) | overtemp | se | oe | ot | (cmd_bits == 8'h00);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mc = 0; mse = 0; moe = 0; mot = 0; exp_status = 0;
        end else begin
            bit lo, sset, oset, sclr, oclr, tclr;
            lo   = (ms == 1);
            sset = cs_rise && lo && (mc < 8);
            oset = sclk_rise && lo && (mc == 8) && !cs_rise;
            sclr = sclk_fall && lo && (mc == 7);
            oclr = sclk_fall && lo && (mc == 1);
            tclr = sclk_fall && lo && (mc == 3) && !overtemp;
            mse = sset | (mse & !sclr);
            moe = oset | (moe & !oclr);
            mot = overtemp | (mot & !tclr);
            exp_status = expect_line(mse, moe, mot);
            case (ms)
                0: if (cs_fall) begin ms = 1; mc = 0; end
                1: if (cs_rise) ms = 0;
                   else if (sclk_rise && mc == 8) ms = 2;
                   else if (sclk_fall && mc < 8) mc = mc + 1;
                default: if (cs_rise) ms = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            n_chk++;
            if (status !== exp_status) begin
                n_err++;
                $display("FAIL mixed-model: status=%0b expected=%0b", status, exp_status);
            end
        end
    end

    task automatic check(input string req, input bit exp);
        n_chk++;
        if (status !== exp) begin
            n_err++;
            $display("FAIL %s: status=%0b expected=%0b", req, status, exp);
        end
    endtask

    // One event cycle; caller sits at a negedge
    task automatic ev(input bit cf, input bit cr, input bit sr, input bit sf);
        cs_fall = cf; cs_rise = cr; sclk_rise = sr; sclk_fall = sf;
        @(negedge clk);
        cs_fall = 0; cs_rise = 0; sclk_rise = 0; sclk_fall = 0;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) begin
            ev(0, 0, 1, 0);
            ev(0, 0, 0, 1);
        end
    endtask

    task automatic frame(input int n);
        ev(1, 0, 0, 0);
        clocks(n);
        ev(0, 1, 0, 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: status=%0b expected=finish", status);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4127));
        repeat (3) @(negedge clk);
        check("R10 reset low", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 quiet after reset", 1'b0);
        model_on = 1'b1;

        // R3 standby self-test
        cmd_bits = 8'h00; @(negedge clk);
        check("R3 standby", 1'b1);
        cmd_bits = 8'h5A; @(negedge clk);
        check("R4 leave standby", 1'b0);

        // R1 live short
        short_flags = 8'h08; @(negedge clk);
        check("R1 short", 1'b1);
        short_flags = 8'h00; @(negedge clk);
        check("R1 short gone", 1'b0);

        // R5 short frame latched
        frame(3);
        check("R5 short frame set", 1'b1);
        repeat (3) @(negedge clk);
        check("R5 short frame held", 1'b1);

        // R6 released by 8th falling clock
        ev(1, 0, 0, 0);
        clocks(7);
        check("R6 held after 7th fall", 1'b1);
        ev(0, 0, 1, 0);
        ev(0, 0, 0, 1);
        check("R6 released at 8th fall", 1'b0);
        ev(0, 1, 0, 0);
        check("R4 exact frame clean", 1'b0);

        // R7 long frame
        ev(1, 0, 0, 0);
        clocks(8);
        check("R7 eight clocks clean", 1'b0);
        ev(0, 0, 1, 0);
        check("R7 ninth rise sets", 1'b1);
        ev(0, 0, 0, 1);
        clocks(2);
        ev(0, 1, 0, 0);
        check("R7 held to frame end", 1'b1);

        // R8 released by 2nd falling clock
        ev(1, 0, 0, 0);
        clocks(1);
        check("R8 held after 1st fall", 1'b1);
        ev(0, 0, 1, 0);
        ev(0, 0, 0, 1);
        check("R8 released at 2nd fall", 1'b0);
        clocks(6);
        ev(0, 1, 0, 0);
        check("R4 frame after long clean", 1'b0);

        // R2 overheat latched
        overtemp = 1'b1; @(negedge clk);
        overtemp = 1'b0; @(negedge clk);
        check("R2 overheat latched", 1'b1);
        @(negedge clk);
        check("R2 overheat held", 1'b1);

        // R9 release blocked while still hot
        ev(1, 0, 0, 0);
        clocks(3);
        check("R9 held after 3rd fall", 1'b1);
        ev(0, 0, 1, 0);
        overtemp = 1'b1;
        ev(0, 0, 0, 1);
        overtemp = 1'b0;
        @(negedge clk);
        check("R9 kept while hot", 1'b1);
        clocks(4);
        ev(0, 1, 0, 0);
        check("R9 kept to frame end", 1'b1);
        ev(1, 0, 0, 0);
        clocks(3);
        check("R9 held after 3rd fall cool", 1'b1);
        ev(0, 0, 1, 0);
        ev(0, 0, 0, 1);
        check("R9 released at 4th fall", 1'b0);
        clocks(4);
        ev(0, 1, 0, 0);
        check("R4 after heat clean", 1'b0);

        // R12 clocks with select high do nothing
        frame(2);
        check("R12 error set", 1'b1);
        for (int i = 0; i < 10; i++) begin
            ev(0, 0, 1, 0);
            ev(0, 0, 0, 1);
        end
        check("R12 idle clocks ignored", 1'b1);
        frame(8);
        check("R12 later frame releases", 1'b0);

        // R11 set wins over release
        frame(3);
        ev(1, 0, 0, 0);
        clocks(7);
        ev(0, 0, 1, 0);
        ev(0, 1, 0, 1);
        check("R11 set wins", 1'b1);
        @(negedge clk);
        check("R11 still set", 1'b1);
        frame(8);
        check("R11 cleaned up", 1'b0);

        // R10 reset clears latches
        frame(1);
        check("R10 error before reset", 1'b1);
        model_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 low in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 latches cleared", 1'b0);
        model_on = 1'b1;

        // Constrained random frames against the model
        for (int f = 0; f < 200; f++) begin
            short_flags = ($urandom_range(0, 5) == 0) ? (8'h01 << $urandom_range(0, 7)) : 8'h00;
            cmd_bits    = ($urandom_range(0, 7) == 0) ? 8'h00 : (8'($urandom()) | 8'h01);
            if ($urandom_range(0, 7) == 0) begin
                overtemp = 1'b1;
                @(negedge clk);
                overtemp = 1'b0;
            end
            frame($urandom_range(0, 12));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule